// File: doc/BRIEF.md
# Winding Chopper Sequencer

This block sequences the two low-side switches of one unipolar stepper winding. The step controller supplies a phase bit, a channel enable and a 4-bit torque code. The block picks which switch charges the coil and drives its gate enable. It also outputs the current reference, as a percentage, for an external DAC and comparator.

Whenever the winding is switched on, and whenever the phase input flips, both gates are held low for a dead interval. This stops the two switches from conducting together. While a switch conducts, the comparator is masked for a short blanking window. After that window, a comparator trip turns the switch off for a fixed off time. The off time is measured in ticks of a slower off-time clock, which arrive as single-cycle enables. Brake forces the reference to full scale. With constant-current regulation disabled, brake closes both switches. Dropping standby or enable opens both switches at once.

Top module: `winding_chopper`

## Requirements
- R1: Once the dead interval has ended and no chop is in progress, phase 1 drives hiOn=1, loOn=0 and phase 0 drives hiOn=0, loOn=1.
- R2: The clock edge that first samples enable and standby both high, or that samples the phase input different from the phase in use, starts a dead interval. Both gates stay 0 for DEAD_CYCLES cycles (default 4). A further phase flip during the interval restarts it.
- R3: enableIn=0 sampled at an edge forces both gates to 0 from that edge on.
- R4: standbyN=0 sampled at an edge forces both gates to 0 from that edge on.
- R5: refLevel follows torqueCode (bit 3 most significant). Codes 0 to 15 map to 0,5,10,15,25,29,38,43,52,60,67,74,80,86,94,100.
- R6: brakeIn=1 forces refLevel to 100 whatever the torque code. With ccOff=0 the phase still selects the conducting side as in R1.
- R7: brakeIn=1 with ccOff=1 (and the channel enabled and not in standby) sampled at an edge turns both gates on from that edge. Leaving this state starts a dead interval.
- R8: During the first BLANK_CYCLES cycles of every conducting interval the comparator input tripIn is ignored.
- R9: A trip sampled after blanking turns the conducting gate off. The gate stays off until OFF_TICKS offTick pulses have been sampled, then conducts again with a fresh blanking window.
- R10: With ccOff=1 the comparator has no effect; the conducting gate stays on.
- R11: A gate never turns on in the cycle right after the opposite gate was on alone. Both gates are on together only in the state of R7.
- R12: After reset both gates are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rstN | input | 1 | active-low asynchronous reset |
| phaseIn | input | 1 | 1 selects the out+ switch, 0 the out- switch |
| enableIn | input | 1 | channel enable; 0 opens both switches |
| torqueCode | input | 4 | current ratio code |
| brakeIn | input | 1 | brake request |
| standbyN | input | 1 | 0 puts the channel into standby |
| ccOff | input | 1 | 1 disables constant-current regulation |
| tripIn | input | 1 | current comparator output, 1 when above threshold |
| offTick | input | 1 | single-cycle enable from the off-time clock |
| hiOn | output | 1 | gate enable of the out+ switch |
| loOn | output | 1 | gate enable of the out- switch |
| refLevel | output | 7 | current reference in percent |

## Verification
The assertions assume that every input is synchronous to clk and stable around the rising edge. They also assume offTick is a plain enable that needs no edge detection. The bench changes all inputs only on the falling edge. It toggles offTick on alternate cycles and drives tripIn from a pseudo-random sequence, so trips land both inside and after blanking windows. Phase flips are placed both within dead intervals and within off times. Brake is applied both with and without constant-current regulation.

// File: rtl/wchop_pkg.sv
package wchop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEAD, ST_ON, ST_CHOP, ST_ALL
  } chopState_t;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic phaseLoad;
  } chopStrobe_t;

  typedef struct packed {
    logic phaseDiff;
    logic deadDone;
    logic blankDone;
    logic offDone;
  } chopFlags_t;
endpackage

// File: rtl/wchop_datapath.sv
module wchop_datapath
  import wchop_pkg::*;
#(
  parameter int DEAD_CYCLES  = 4,
  parameter int BLANK_CYCLES = 3,
  parameter int OFF_TICKS    = 32,
  parameter int CW           = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  chopStrobe_t stb,
  input  logic        phaseIn,
  input  logic [3:0]  torqueCode,
  input  logic        brakeIn,
  output chopFlags_t  flags,
  output logic        curPhase,
  output logic [6:0]  refLevel
);
  localparam logic [CW-1:0] DEAD_LAST = CW'(DEAD_CYCLES - 1);
  localparam logic [CW-1:0] BLANK_END = CW'(BLANK_CYCLES);
  localparam logic [CW-1:0] OFF_LAST  = CW'(OFF_TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      curPhase <= 1'b0;
    end else begin
      if (stb.cntClr)      cnt <= '0;
      else if (stb.cntInc) cnt <= cnt + 1'b1;
      if (stb.phaseLoad)   curPhase <= phaseIn;
    end
  end

  always_comb begin
    flags.phaseDiff = (phaseIn != curPhase);
    flags.deadDone  = (cnt == DEAD_LAST);
    flags.blankDone = (cnt >= BLANK_END);
    flags.offDone   = (cnt == OFF_LAST);
  end

  function automatic logic [6:0] ratioOf(input logic [3:0] code);
    case (code)
      4'd0:  ratioOf = 7'd0;
      4'd1:  ratioOf = 7'd5;
      4'd2:  ratioOf = 7'd10;
      4'd3:  ratioOf = 7'd15;
      4'd4:  ratioOf = 7'd25;
      4'd5:  ratioOf = 7'd29;
      4'd6:  ratioOf = 7'd38;
      4'd7:  ratioOf = 7'd43;
      4'd8:  ratioOf = 7'd52;
      4'd9:  ratioOf = 7'd60;
      4'd10: ratioOf = 7'd67;
      4'd11: ratioOf = 7'd74;
      4'd12: ratioOf = 7'd80;
      4'd13: ratioOf = 7'd86;
      4'd14: ratioOf = 7'd94;
      default: ratioOf = 7'd100;
    endcase
  endfunction

  assign refLevel = brakeIn ? 7'd100 : ratioOf(torqueCode);

  // R6
  brake_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    brakeIn |-> refLevel == 7'd100);
endmodule

// File: rtl/wchop_control.sv
module wchop_control
  import wchop_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enableIn,
  input  logic        standbyN,
  input  logic        brakeIn,
  input  logic        ccOff,
  input  logic        tripIn,
  input  logic        offTick,
  input  chopFlags_t  flags,
  input  logic        curPhase,
  output chopStrobe_t stb,
  output logic        hiOn,
  output logic        loOn
);
  chopState_t state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt = state;
    stb = '0;
    if (!standbyN || !enableIn) begin
      nxt = ST_IDLE;
      stb.phaseLoad = 1'b1;
      stb.cntClr = 1'b1;
    end else if (brakeIn && ccOff) begin
      nxt = ST_ALL;
      stb.cntClr = 1'b1;
    end else if (state == ST_IDLE || state == ST_ALL || flags.phaseDiff) begin
      nxt = ST_DEAD;
      stb.phaseLoad = 1'b1;
      stb.cntClr = 1'b1;
    end else begin
      case (state)
        ST_DEAD: begin
          if (flags.deadDone) begin
            nxt = ST_ON;
            stb.cntClr = 1'b1;
          end else stb.cntInc = 1'b1;
        end
        ST_ON: begin
          if (!ccOff && flags.blankDone && tripIn) begin
            nxt = ST_CHOP;
            stb.cntClr = 1'b1;
          end else if (!flags.blankDone) stb.cntInc = 1'b1;
        end
        ST_CHOP: begin
          if (offTick) begin
            if (flags.offDone) begin
              nxt = ST_ON;
              stb.cntClr = 1'b1;
            end else stb.cntInc = 1'b1;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  assign hiOn = (state == ST_ON && curPhase)  || state == ST_ALL;
  assign loOn = (state == ST_ON && !curPhase) || state == ST_ALL;

  // R3
  enable_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enableIn |=> !hiOn && !loOn);
  // R4
  standby_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !standbyN |=> !hiOn && !loOn);
  // R11
  no_direct_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loOn && !hiOn) |=> !(hiOn && !loOn));
  // R11
  no_direct_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hiOn && !loOn) |=> !(loOn && !hiOn));
  // R7
  both_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brakeIn && ccOff && enableIn && standbyN) |=> hiOn && loOn);
  // R10
  no_chop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ccOff && !brakeIn && enableIn && standbyN && !flags.phaseDiff && (hiOn ^ loOn))
      |=> (hiOn ^ loOn));
endmodule

// File: rtl/winding_chopper.sv
module winding_chopper
  import wchop_pkg::*;
#(
  parameter int DEAD_CYCLES  = 4,
  parameter int BLANK_CYCLES = 3,
  parameter int OFF_TICKS    = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       phaseIn,
  input  logic       enableIn,
  input  logic [3:0] torqueCode,
  input  logic       brakeIn,
  input  logic       standbyN,
  input  logic       ccOff,
  input  logic       tripIn,
  input  logic       offTick,
  output logic       hiOn,
  output logic       loOn,
  output logic [6:0] refLevel
);
  localparam int MAXC = (DEAD_CYCLES > BLANK_CYCLES)
                      ? ((DEAD_CYCLES > OFF_TICKS) ? DEAD_CYCLES : OFF_TICKS)
                      : ((BLANK_CYCLES > OFF_TICKS) ? BLANK_CYCLES : OFF_TICKS);
  localparam int CW = $clog2(MAXC + 1);

  chopStrobe_t stb;
  chopFlags_t  flags;
  logic        curPhase;

  wchop_datapath #(
    .DEAD_CYCLES(DEAD_CYCLES), .BLANK_CYCLES(BLANK_CYCLES),
    .OFF_TICKS(OFF_TICKS), .CW(CW)
  ) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .phaseIn(phaseIn),
    .torqueCode(torqueCode), .brakeIn(brakeIn), .flags(flags),
    .curPhase(curPhase), .refLevel(refLevel)
  );

  wchop_control ctl (
    .clk(clk), .rstN(rstN), .enableIn(enableIn), .standbyN(standbyN),
    .brakeIn(brakeIn), .ccOff(ccOff), .tripIn(tripIn), .offTick(offTick),
    .flags(flags), .curPhase(curPhase), .stb(stb), .hiOn(hiOn), .loOn(loOn)
  );
endmodule

// File: tb/winding_chopper_test.sv
module winding_chopper_test;
  localparam int DEAD  = 4;
  localparam int BLANK = 3;
  localparam int OFFN  = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic phaseIn = 1'b0, enableIn = 1'b0, brakeIn = 1'b0, standbyN = 1'b0;
  logic ccOff = 1'b0, tripIn = 1'b0, offTick = 1'b0;
  logic [3:0] torqueCode = 4'd0;
  logic hiOn, loOn;
  logic [6:0] refLevel;

  int checks = 0, fails = 0;
  string curReq = "R12";
  bit done = 1'b0;

  // reference model state
  int mMode = 0; // 0 idle 1 dead 2 on 3 chop 4 all
  int mPh = 0, mDead = 0, mBlank = 0, mOff = 0;
  int lfsr = 7;

  winding_chopper #(.DEAD_CYCLES(DEAD), .BLANK_CYCLES(BLANK), .OFF_TICKS(OFFN)) uut (
    .clk(clk), .rstN(rstN), .phaseIn(phaseIn), .enableIn(enableIn),
    .torqueCode(torqueCode), .brakeIn(brakeIn), .standbyN(standbyN),
    .ccOff(ccOff), .tripIn(tripIn), .offTick(offTick),
    .hiOn(hiOn), .loOn(loOn), .refLevel(refLevel)
  );

  always #10 clk = ~clk;

  function automatic int pct(input int c);
    int t[16] = '{0, 5, 10, 15, 25, 29, 38, 43, 52, 60, 67, 74, 80, 86, 94, 100};
    return t[c];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mPh = 0;
    end else if (!standbyN || !enableIn) begin
      mMode = 0; mPh = phaseIn;
    end else if (brakeIn && ccOff) begin
      mMode = 4;
    end else if (mMode == 0 || mMode == 4 || phaseIn != mPh) begin
      mMode = 1; mDead = DEAD; mPh = phaseIn;
    end else if (mMode == 1) begin
      mDead--;
      if (mDead == 0) begin mMode = 2; mBlank = 0; end
    end else if (mMode == 2) begin
      if (!ccOff && mBlank >= BLANK && tripIn) begin mMode = 3; mOff = 0; end
      else if (mBlank < BLANK) mBlank++;
    end else if (mMode == 3) begin
      if (offTick) begin
        mOff++;
        if (mOff == OFFN) begin mMode = 2; mBlank = 0; end
      end
    end
  end

  task automatic compare();
    logic eh, el;
    int er;
    eh = (mMode == 2 && mPh == 1) || mMode == 4;
    el = (mMode == 2 && mPh == 0) || mMode == 4;
    er = brakeIn ? 100 : pct(torqueCode);
    checks++;
    if (hiOn !== eh || loOn !== el || int'(refLevel) != er) begin
      fails++;
      $display("FAIL %s: hi/lo/ref actual %b/%b/%0d expected %b/%b/%0d",
               curReq, hiOn, loOn, refLevel, eh, el, er);
    end
  endtask

  task automatic step(input int n, input bit randTrip);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      offTick = ~offTick;
      if (randTrip) begin
        lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
        tripIn = lfsr[9];
      end
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R12 reset state
    step(3, 0);
    rstN = 1'b1;
    step(2, 0);
    // R1 R2 R5: enable with phase high, sweep torque
    curReq = "R2";
    standbyN = 1'b1; enableIn = 1'b1; phaseIn = 1'b1;
    step(8, 0);
    curReq = "R5";
    for (int c = 0; c < 16; c++) begin torqueCode = 4'(c); step(2, 0); end
    curReq = "R1";
    phaseIn = 1'b0;
    step(10, 0);
    // R2 flip during dead interval
    curReq = "R2";
    phaseIn = 1'b1; step(2, 0); phaseIn = 1'b0; step(2, 0); phaseIn = 1'b1;
    step(10, 0);
    // R8 R9 trip held high
    curReq = "R8";
    tripIn = 1'b1; step(3, 0);
    curReq = "R9";
    step(30, 0);
    tripIn = 1'b0; step(4, 0);
    // random trips with phase flips
    curReq = "R9";
    for (int k = 0; k < 6; k++) begin phaseIn = ~phaseIn; step(40, 1); end
    // R10 regulation disabled
    curReq = "R10";
    ccOff = 1'b1; tripIn = 1'b1; step(20, 0);
    tripIn = 1'b0;
    // R6 brake with regulation active
    curReq = "R6";
    ccOff = 1'b0; brakeIn = 1'b1; torqueCode = 4'd3; step(8, 0);
    phaseIn = ~phaseIn; step(8, 0);
    // R7 brake with regulation disabled
    curReq = "R7";
    ccOff = 1'b1; step(6, 0);
    brakeIn = 1'b0; step(8, 0);
    // R11 mixed switching
    curReq = "R11";
    ccOff = 1'b0;
    for (int k = 0; k < 4; k++) begin
      brakeIn = 1'b1; ccOff = 1'b1; step(2, 0);
      ccOff = 1'b0; brakeIn = 1'b0; phaseIn = ~phaseIn; step(6, 1);
    end
    // R3 enable low
    curReq = "R3";
    enableIn = 1'b0; step(4, 0); enableIn = 1'b1; step(8, 0);
    // R4 standby
    curReq = "R4";
    standbyN = 1'b0; brakeIn = 1'b1; ccOff = 1'b1; step(4, 0);
    standbyN = 1'b1; brakeIn = 1'b0; ccOff = 1'b0; step(8, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule